// File: doc/BRIEF.md
# Phase-Slot Start Aligner

This block launches work in two phase-locked clock domains on the same instant. The fast clock runs at exactly four times the slow clock, and every slow rising edge lands on a fast rising edge. An asynchronous start request, such as a push button, is synchronized and edge-detected in the slow domain. The block then issues a one-cycle strobe to each domain so that a slow consumer and a fast consumer both register their strobe on the same shared rising edge.

The fast domain does not assume a fixed delay from the slow domain. A flag that toggles on every slow edge is sampled in the fast domain. The fast edge on which the sampled flag changes is slot 2 of the slow period, and a modulo-4 slot counter reloads from that mark. This keeps the phase tracked continuously. The fast strobe is placed in the slot-4 cycle, the last fast cycle before the next shared edge. A lock indicator gates the fast strobe until the slot counter has proven its phase. A request that arrives before lock is held and released once lock is reached.

Top module: `start_aligner`

## Requirements
- R1: A rising edge on `start_i`, held for at least two slow cycles, produces a `slow_start_o` pulse exactly one slow cycle wide. A start held high for many cycles produces only that one pulse.
- R2: While `locked_o` is high, `slot_o` holds k-1, where k is the slot number (1 to 4) of the most recent fast rising edge. Slot 1 is the fast edge that coincides with a slow rising edge, so the encoding is 0 for slot 1, 1 for slot 2, 2 for slot 3 and 3 for slot 4. The value advances by one, modulo 4, on every fast edge.
- R3: `locked_o` is low when reset is released. With steady phase-locked clocks it rises within a bounded number of slow periods, and it then stays high.
- R4: `fast_start_o` is high for exactly one fast cycle at a time. It is only ever high while `slot_o` is 3 (the slot-4 cycle) and `locked_o` is high.
- R5: For a start detected while locked, the fast consumer registers `fast_start_o` on the same absolute rising edge on which the slow consumer registers `slow_start_o`.
- R6: A start detected while unlocked produces no `fast_start_o` before lock. It produces exactly one `fast_start_o`, in the first slot-4 cycle after `locked_o` rises.
- R7: While `rst_ni` is low, all outputs are 0. Each clock domain releases reset through its own synchronizer.
- R8: Each `slow_start_o` pulse yields exactly one `fast_start_o` pulse: no strobe is dropped and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow clock |
| clk_fast_i | input | 1 | Fast clock, 4x the slow rate, rising edges phase-locked |
| rst_ni | input | 1 | Active-low asynchronous reset, released per domain through a synchronizer |
| start_i | input | 1 | Asynchronous start request |
| slow_start_o | output | 1 | One-slow-cycle start strobe |
| fast_start_o | output | 1 | One-fast-cycle start strobe in the slot-4 cycle |
| slot_o | output | 2 | Slot index of the last fast edge, 0 = slot 1 |
| locked_o | output | 1 | Slot counter phase confirmed |

## Verification
The start input is raised at several offsets within the slow period, from just after a shared edge to just before the next one. This shows that the fast strobe always lands in slot 4 and is taken on the same edge as the slow strobe, whatever the phase of the asynchronous input. A start held high for many slow periods separates true edge detection from level sensing. A start held across reset release forces a request to arrive before lock, which tests the pending path. The slot index is compared against a count of absolute fast edges derived from simulation time, before and after the other scenarios, which exposes counter drift or a wrong reload value.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int SLOT_W = 2;
  typedef logic [SLOT_W-1:0] slot_t;
  // slot encoding: 0 = slot 1 (shared edge) .. 3 = slot 4
  localparam slot_t SLOT_MARK   = 2'd1;  // edge where toggle change is first seen
  localparam slot_t SLOT_RELOAD = 2'd2;  // value loaded on the edge after the mark
  localparam slot_t SLOT_PRE    = 2'd2;  // fire decision taken in this cycle
  localparam slot_t SLOT_LAST   = 2'd3;
endpackage

// File: rtl/sa_rst_sync.sv
module sa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sa_slow_side.sv
module sa_slow_side #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic start_o,
  output logic toggle_o
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;
  logic              start_q;
  logic              tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      hist_q  <= 1'b0;
      start_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[STAGES-2:0], start_i};
      hist_q  <= sync_q[STAGES-1];
      start_q <= sync_q[STAGES-1] & ~hist_q;
      tog_q   <= ~tog_q;
    end
  end

  assign start_o  = start_q;
  assign toggle_o = tog_q;

  // R1
  slow_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
endmodule

// File: rtl/sa_slot_tracker.sv
module sa_slot_tracker
  import sa_pkg::*;
#(
  parameter int LOCK_HITS = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  toggle_i,
  output slot_t slot_o,
  output logic  locked_o
);
  localparam int HIT_W = $clog2(LOCK_HITS + 1);

  logic [1:0]       samp_q;
  slot_t            slot_q;
  logic             seen_q;
  logic [HIT_W-1:0] hits_q;
  logic             mark;
  logic             locked;

  assign mark   = samp_q[0] ^ samp_q[1];
  assign locked = (hits_q == HIT_W'(LOCK_HITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      slot_q <= '0;
      seen_q <= 1'b0;
      hits_q <= '0;
    end else begin
      samp_q <= {samp_q[0], toggle_i};
      if (mark) begin
        slot_q <= SLOT_RELOAD;
        seen_q <= 1'b1;
        if (seen_q && slot_q == SLOT_MARK)
          hits_q <= locked ? hits_q : hits_q + 1'b1;
        else
          hits_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign slot_o   = slot_q;
  assign locked_o = locked;

  // R2
  slot_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && $past(locked)) |-> (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/sa_fast_launch.sv
module sa_fast_launch
  import sa_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  slot_t slot_i,
  input  logic  locked_i,
  output logic  strobe_o
);
  logic [1:0] samp_q;
  logic       pend_q;
  logic       strobe_q;
  logic       new_req;
  logic       fire;

  assign new_req = samp_q[0] & ~samp_q[1];
  assign fire    = locked_i && (slot_i == SLOT_PRE) && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q   <= '0;
      pend_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      samp_q   <= {samp_q[0], req_i};
      pend_q   <= new_req | (pend_q & ~fire);
      strobe_q <= fire;
    end
  end

  assign strobe_o = strobe_q;

  // R4
  fast_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);
  // R4
  fast_in_last_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> (slot_i == SLOT_LAST));
  // R4
  fast_only_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> locked_i);
endmodule

// File: rtl/start_aligner.sv
module start_aligner
  import sa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_HITS   = 3
) (
  input  logic              clk_slow_i,
  input  logic              clk_fast_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              slow_start_o,
  output logic              fast_start_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              locked_o
);
  logic  rst_slow_n;
  logic  rst_fast_n;
  logic  slow_start;
  logic  toggle;
  slot_t slot;
  logic  locked;

  // R7: per-domain reset release
  sa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_slow (
    .clk_i (clk_slow_i),
    .rst_ni(rst_ni),
    .rst_no(rst_slow_n)
  );

  sa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_fast (
    .clk_i (clk_fast_i),
    .rst_ni(rst_ni),
    .rst_no(rst_fast_n)
  );

  sa_slow_side #(.STAGES(SYNC_STAGES)) u_slow (
    .clk_i   (clk_slow_i),
    .rst_ni  (rst_slow_n),
    .start_i (start_i),
    .start_o (slow_start),
    .toggle_o(toggle)
  );

  sa_slot_tracker #(.LOCK_HITS(LOCK_HITS)) u_track (
    .clk_i   (clk_fast_i),
    .rst_ni  (rst_fast_n),
    .toggle_i(toggle),
    .slot_o  (slot),
    .locked_o(locked)
  );

  sa_fast_launch u_launch (
    .clk_i   (clk_fast_i),
    .rst_ni  (rst_fast_n),
    .req_i   (slow_start),
    .slot_i  (slot),
    .locked_i(locked),
    .strobe_o(fast_start_o)
  );

  assign slow_start_o = slow_start;
  assign slot_o       = slot;
  assign locked_o     = locked;
endmodule

// File: tb/start_aligner_tb_top.sv
module start_aligner_tb_top;
  localparam int CLK_PERIOD = 10;           // fast clock
  localparam int SLOW_PERIOD = 4 * CLK_PERIOD;

  logic       clk_fast = 1'b0;
  logic       clk_slow = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       slow_start_o;
  logic       fast_start_o;
  logic [1:0] slot_o;
  logic       locked_o;

  int     checks = 0;
  int     errors = 0;
  int     fast_cnt = 0;
  int     slow_cnt = 0;
  longint fast_take = 0;
  longint slow_take = 0;

  start_aligner dut_i (
    .clk_slow_i  (clk_slow),
    .clk_fast_i  (clk_fast),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .slow_start_o(slow_start_o),
    .fast_start_o(fast_start_o),
    .slot_o      (slot_o),
    .locked_o    (locked_o)
  );

  // fast rises at 5+10n, slow rises at 5+40k: shared edges
  initial forever #(CLK_PERIOD/2) clk_fast = ~clk_fast;
  initial begin
    #(CLK_PERIOD/2);
    forever begin
      clk_slow = ~clk_slow;
      #(SLOW_PERIOD/2);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // strobes seen mid-cycle are taken by consumers at the following rising edge
  always @(negedge clk_fast) begin
    if (fast_start_o) begin
      fast_cnt++;
      fast_take = longint'($time) + CLK_PERIOD/2;
      check(slot_o == 2'd3, "R4 slot during fast strobe", slot_o, 3);
      check(locked_o, "R4 locked during fast strobe", locked_o, 1);
    end
  end

  always @(negedge clk_slow) begin
    if (slow_start_o) begin
      slow_cnt++;
      slow_take = longint'($time) + SLOW_PERIOD/2;
    end
  end

  task automatic wait_slow(input int n);
    repeat (n) @(posedge clk_slow);
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    start_i = 1'b0;
    wait_slow(3);
    @(negedge clk_fast);
    check(!slow_start_o && !fast_start_o && slot_o == 2'd0 && !locked_o,
          "R7 outputs in reset", {slow_start_o, fast_start_o, slot_o, locked_o}, 0);
    #3 rst_ni = 1'b1;
    @(negedge clk_fast);
    check(!locked_o, "R3 unlocked after release", locked_o, 0);
  endtask

  task automatic wait_lock();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_fast);
      if (locked_o) break;
    end
    check(locked_o, "R3 lock reached", locked_o, 1);
  endtask

  task automatic check_slots();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_fast);
      check(int'(slot_o) == (int'($time / CLK_PERIOD) - 1) % 4, "R2 slot index",
            slot_o, (int'($time / CLK_PERIOD) - 1) % 4);
      check(locked_o, "R3 lock held", locked_o, 1);
    end
  endtask

  task automatic single_start(input int offset, input int hold_slow);
    int f0, s0;
    f0 = fast_cnt;
    s0 = slow_cnt;
    @(posedge clk_slow);
    #offset start_i = 1'b1;
    #(hold_slow * SLOW_PERIOD + 7) start_i = 1'b0;
    wait_slow(8);
    check(slow_cnt - s0 == 1, "R1 one slow strobe cycle", slow_cnt - s0, 1);
    check(fast_cnt - f0 == 1, "R8 one fast strobe", fast_cnt - f0, 1);
    check(fast_take == slow_take, "R5 same take edge", fast_take, slow_take);
  endtask

  task automatic pending_start();
    int     f0, s0;
    longint lock_t;
    rst_ni  = 1'b0;
    start_i = 1'b1;
    wait_slow(3);
    f0 = fast_cnt;
    s0 = slow_cnt;
    #3 rst_ni = 1'b1;
    lock_t = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_fast);
      if (locked_o) begin
        lock_t = longint'($time);
        break;
      end
    end
    check(locked_o, "R3 relock", locked_o, 1);
    check(fast_cnt == f0, "R6 no fast strobe before lock", fast_cnt - f0, 0);
    wait_slow(8);
    start_i = 1'b0;
    wait_slow(2);
    check(fast_cnt - f0 == 1, "R6 pending released once", fast_cnt - f0, 1);
    check(fast_take > lock_t && fast_take - lock_t <= 4 * CLK_PERIOD + CLK_PERIOD/2,
          "R6 first slot 4 after lock", fast_take - lock_t, CLK_PERIOD + CLK_PERIOD/2);
    check(slow_cnt - s0 == 1, "R1 slow strobe on held start", slow_cnt - s0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    wait_lock();
    check_slots();
    single_start(1, 2);
    single_start(13, 2);
    single_start(27, 3);
    single_start(39, 2);
    single_start(22, 20);   // R1 held start, no retrigger
    pending_start();
    check_slots();
    single_start(8, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule